// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

The blitter performs two framebuffer operations through a byte-wide memory port. A fill paints a rectangle with one colour. A copy moves a rectangle from a source position to a destination position. The framebuffer is linear. A pixel sits at `fb_base + bpp*x + pitch*y`, and the pitch is `bpp * scr_width`. An operation is launched with a one-cycle `start` pulse while `busy` is low. Every operand is captured on that cycle. When the operation ends, `done` pulses for one cycle.

A copy chooses its row order and byte order from the relative source and destination positions, so overlapping rectangles end up as a true move. Every operation, including an empty one, records its destination rectangle in a ring of dirty regions. The consumer drains the ring with `dirty_pop`. The head entry is presented clipped against the current screen size. `dirty_invalidate` drops every pending entry, for the case where the whole screen will be redrawn anyway.

Top module: `rect_blit_engine`

## Requirements
- R1: Every fill or copy byte of pixel (x, y), byte k, is written at `fb_base + bpp*x + bpp*scr_width*y + k`, with `bpp` given as the plain value 1, 2, 3 or 4.
- R2: A fill writes byte k of each pixel with byte k of `fill_colour`, least significant byte first. The pattern restarts every `bpp` bytes along the row. A fill of N bytes makes N writes, one per cycle, and `done` is high on the cycle after the last write.
- R3: A copy leaves the destination equal to the original source contents, including when the regions overlap and `dst_y > src_y`. In that case rows are processed from the bottom up. Each byte takes a read cycle followed by a write cycle, so N bytes end with `done` 2N+1 cycles after `start`.
- R4: When `dst_y < src_y` rows are processed top-down. When `dst_y == src_y` and `dst_x > src_x` the bytes of each row go right to left, otherwise left to right. A copy that overlaps in any of these ways still produces the original source image at the destination.
- R5: After reset `busy`, `done` and `dirty_valid` are low. `done` is a single-cycle pulse.
- R6: Each completed operation appends its destination (x, y, w, h) to a ring of QDEPTH entries (default 512). Entries are read in arrival order, and a pop while empty has no effect.
- R7: The head entry is shown with horizontal clipping. If x + w exceeds `scr_width`, x becomes min(x, `scr_width`) and w becomes `scr_width` − x.
- R8: The same clipping rule applies vertically against `scr_height`.
- R9: A `dirty_invalidate` pulse discards all entries pending before that cycle, so `dirty_valid` goes low.
- R10: A zero width or zero height performs no memory access. `done` still rises on the next cycle, and the zero-sized entry is still queued.
- R11: `bpp`, coordinates, sizes and colour are sampled at `start`. Changing them, or pulsing `start` again while `busy`, has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch an operation (taken when idle) |
| op_copy | input | 1 | 1 = copy, 0 = fill |
| bpp | input | 3 | Bytes per pixel, 1..4 |
| scr_width | input | COORD_W | Screen width in pixels (pitch and clipping) |
| scr_height | input | COORD_W | Screen height in pixels (clipping) |
| fb_base | input | ADDR_W | Framebuffer byte base address |
| src_x | input | COORD_W | Copy source x |
| src_y | input | COORD_W | Copy source y |
| dst_x | input | COORD_W | Destination x |
| dst_y | input | COORD_W | Destination y |
| rect_w | input | COORD_W | Rectangle width in pixels |
| rect_h | input | COORD_W | Rectangle height in rows |
| fill_colour | input | 32 | Fill colour, little-endian bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Byte read request |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after request |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 8 | Write data |
| dirty_invalidate | input | 1 | Drop all pending dirty entries |
| dirty_pop | input | 1 | Consume the head dirty entry |
| dirty_valid | output | 1 | Ring holds at least one entry |
| dirty_x | output | COORD_W | Clipped head x |
| dirty_y | output | COORD_W | Clipped head y |
| dirty_w | output | COORD_W | Clipped head width |
| dirty_h | output | COORD_W | Clipped head height |

## Verification
The hardest behaviour to reach from the ports is overlapping copies. Ordering only matters when the source and destination share bytes, so a wrong choice of row or byte direction is invisible on disjoint rectangles. The stimulus preloads the framebuffer model with a position-dependent pattern. It then runs copies shifted by one or two pixels down, up-and-right, and along the same row in both directions. Each result is compared against a snapshot-then-paste model. Clipping is reached by shrinking the screen size inputs after entries were queued, so the stored rectangles overhang the edge.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_FILL,
    WS_CRD,
    WS_CWR,
    WS_FIN
  } walk_state_e;

endpackage

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_copy,
  input  logic [2:0]         bpp,
  input  logic [COORD_W-1:0] scr_width,
  input  logic [ADDR_W-1:0]  fb_base,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  input  logic [31:0]        fill_colour,
  input  logic [7:0]         mem_rd_data,
  output logic               busy,
  output logic               done,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [7:0]         mem_wr_data,
  output logic [COORD_W-1:0] rect_x_q,
  output logic [COORD_W-1:0] rect_y_q,
  output logic [COORD_W-1:0] rect_w_q,
  output logic [COORD_W-1:0] rect_h_q
);

  localparam int RB_W = COORD_W + 2;

  // Byte address of pixel (x, y) on a screen of scrw pixels per row
  function automatic logic [ADDR_W-1:0] pix_addr(
    input logic [ADDR_W-1:0]  base,
    input logic [2:0]         bytes_pp,
    input logic [COORD_W-1:0] x,
    input logic [COORD_W-1:0] y,
    input logic [COORD_W-1:0] scrw
  );
    logic [ADDR_W-1:0] pitch;
    pitch = ADDR_W'(bytes_pp) * ADDR_W'(scrw);
    return base + ADDR_W'(bytes_pp) * ADDR_W'(x) + pitch * ADDR_W'(y);
  endfunction

  walk_state_e st;
  logic               copy_q;
  logic [2:0]         bpp_q;
  logic [COORD_W-1:0] scrw_q;
  logic [ADDR_W-1:0]  base_q;
  logic [COORD_W-1:0] sx_q, sy_q;
  logic [31:0]        col_q;
  logic [RB_W-1:0]    rowb_q;
  logic [RB_W-1:0]    bcnt;
  logic [COORD_W-1:0] rcnt;
  logic [1:0]         phase;
  logic               rev_rows, rev_bytes;

  // Named internal events
  logic               last_byte, last_row, last_all, empty_req;
  logic [COORD_W-1:0] row_off;
  logic [RB_W-1:0]    byte_off;
  logic [RB_W-1:0]    bcnt_nx;
  logic [COORD_W-1:0] rcnt_nx;
  logic [1:0]         phase_nx;

  assign last_byte = (bcnt == rowb_q - RB_W'(1));
  assign last_row  = (rcnt == rect_h_q - COORD_W'(1));
  assign last_all  = last_byte && last_row;
  assign empty_req = (rect_w == '0) || (rect_h == '0);

  always_comb begin
    row_off  = rev_rows  ? (rect_h_q - COORD_W'(1) - rcnt) : rcnt;
    byte_off = rev_bytes ? (rowb_q - RB_W'(1) - bcnt) : bcnt;
    if (last_byte) begin
      bcnt_nx  = '0;
      rcnt_nx  = rcnt + COORD_W'(1);
      phase_nx = '0;
    end else begin
      bcnt_nx  = bcnt + RB_W'(1);
      rcnt_nx  = rcnt;
      phase_nx = ({1'b0, phase} == bpp_q - 3'd1) ? 2'd0 : phase + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= WS_IDLE;
      copy_q    <= 1'b0;
      bpp_q     <= 3'd1;
      scrw_q    <= '0;
      base_q    <= '0;
      sx_q      <= '0;
      sy_q      <= '0;
      rect_x_q  <= '0;
      rect_y_q  <= '0;
      rect_w_q  <= '0;
      rect_h_q  <= '0;
      col_q     <= '0;
      rowb_q    <= '0;
      bcnt      <= '0;
      rcnt      <= '0;
      phase     <= '0;
      rev_rows  <= 1'b0;
      rev_bytes <= 1'b0;
    end else begin
      unique case (st)
        WS_IDLE: begin
          if (start) begin
            copy_q    <= op_copy;
            bpp_q     <= bpp;
            scrw_q    <= scr_width;
            base_q    <= fb_base;
            sx_q      <= src_x;
            sy_q      <= src_y;
            rect_x_q  <= dst_x;
            rect_y_q  <= dst_y;
            rect_w_q  <= rect_w;
            rect_h_q  <= rect_h;
            col_q     <= fill_colour;
            rowb_q    <= RB_W'(bpp) * RB_W'(rect_w);
            bcnt      <= '0;
            rcnt      <= '0;
            phase     <= '0;
            rev_rows  <= op_copy && (dst_y > src_y);
            rev_bytes <= op_copy && (dst_y == src_y) && (dst_x > src_x);
            if (empty_req)    st <= WS_FIN;
            else if (op_copy) st <= WS_CRD;
            else              st <= WS_FILL;
          end
        end
        WS_FILL: begin
          bcnt  <= bcnt_nx;
          rcnt  <= rcnt_nx;
          phase <= phase_nx;
          if (last_all) st <= WS_FIN;
        end
        WS_CRD: st <= WS_CWR;
        WS_CWR: begin
          bcnt  <= bcnt_nx;
          rcnt  <= rcnt_nx;
          phase <= phase_nx;
          st    <= last_all ? WS_FIN : WS_CRD;
        end
        WS_FIN:  st <= WS_IDLE;
        default: st <= WS_IDLE;
      endcase
    end
  end

  assign busy        = (st != WS_IDLE);
  assign done        = (st == WS_FIN);
  assign mem_rd_en   = (st == WS_CRD);
  assign mem_wr_en   = (st == WS_FILL) || (st == WS_CWR);
  assign mem_rd_addr = pix_addr(base_q, bpp_q, sx_q, sy_q + row_off, scrw_q)
                       + ADDR_W'(byte_off);
  assign mem_wr_addr = pix_addr(base_q, bpp_q, rect_x_q, rect_y_q + row_off, scrw_q)
                       + ADDR_W'(byte_off);
  assign mem_wr_data = (st == WS_CWR) ? mem_rd_data : col_q[{phase, 3'b000} +: 8];

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_en && !mem_rd_en));

  // R10
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && empty_req) |=> (done && !mem_wr_en && !mem_rd_en));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R2
  fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !copy_q) |-> !mem_rd_en);

endmodule

// File: rtl/dirty_ring.sv
module dirty_ring #(
  parameter int COORD_W = 12,
  parameter int QDEPTH  = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [COORD_W-1:0] push_x,
  input  logic [COORD_W-1:0] push_y,
  input  logic [COORD_W-1:0] push_w,
  input  logic [COORD_W-1:0] push_h,
  input  logic               invalidate,
  input  logic               pop,
  input  logic [COORD_W-1:0] lim_w,
  input  logic [COORD_W-1:0] lim_h,
  output logic               valid,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic [COORD_W-1:0] out_w,
  output logic [COORD_W-1:0] out_h
);

  localparam int PTR_W = $clog2(QDEPTH);
  localparam int ENT_W = 4 * COORD_W;

  // Clip one axis: returns {start, length}
  function automatic logic [2*COORD_W-1:0] clip_axis(
    input logic [COORD_W-1:0] pos,
    input logic [COORD_W-1:0] len,
    input logic [COORD_W-1:0] lim
  );
    logic [COORD_W:0]   sum;
    logic [COORD_W-1:0] np;
    sum = {1'b0, pos} + {1'b0, len};
    if (sum > {1'b0, lim}) begin
      np = (pos > lim) ? lim : pos;
      return {np, lim - np};
    end
    return {pos, len};
  endfunction

  logic [ENT_W-1:0] store [QDEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENT_W-1:0] head;
  logic             do_pop;

  assign valid  = (wr_ptr != rd_ptr);
  assign do_pop = pop && valid && !invalidate;
  assign head   = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= {push_x, push_y, push_w, push_h};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (invalidate)  rd_ptr <= wr_ptr;
      else if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
    end
  end

  assign {out_x, out_w} = clip_axis(head[ENT_W-1 -: COORD_W], head[2*COORD_W-1 -: COORD_W], lim_w);
  assign {out_y, out_h} = clip_axis(head[3*COORD_W-1 -: COORD_W], head[COORD_W-1:0], lim_h);

  // R6
  push_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !invalidate) |=> valid);

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (invalidate && !push) |=> !valid);

  // R7
  clip_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ({1'b0, out_x} + {1'b0, out_w} <= {1'b0, lim_w}) || (out_x + out_w == head[ENT_W-1 -: COORD_W] + head[2*COORD_W-1 -: COORD_W]));

  // R8
  clip_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ({1'b0, out_y} <= {1'b0, lim_h}) || (out_y == head[3*COORD_W-1 -: COORD_W]));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !push) |=> !valid);

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine #(
  parameter int ADDR_W  = 24,
  parameter int COORD_W = 12,
  parameter int QDEPTH  = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_copy,
  input  logic [2:0]         bpp,
  input  logic [COORD_W-1:0] scr_width,
  input  logic [COORD_W-1:0] scr_height,
  input  logic [ADDR_W-1:0]  fb_base,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [COORD_W-1:0] rect_w,
  input  logic [COORD_W-1:0] rect_h,
  input  logic [31:0]        fill_colour,
  output logic               busy,
  output logic               done,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic [7:0]         mem_rd_data,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [7:0]         mem_wr_data,
  input  logic               dirty_invalidate,
  input  logic               dirty_pop,
  output logic               dirty_valid,
  output logic [COORD_W-1:0] dirty_x,
  output logic [COORD_W-1:0] dirty_y,
  output logic [COORD_W-1:0] dirty_w,
  output logic [COORD_W-1:0] dirty_h
);

  logic [COORD_W-1:0] op_x, op_y, op_w, op_h;

  blit_walker #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_copy     (op_copy),
    .bpp         (bpp),
    .scr_width   (scr_width),
    .fb_base     (fb_base),
    .src_x       (src_x),
    .src_y       (src_y),
    .dst_x       (dst_x),
    .dst_y       (dst_y),
    .rect_w      (rect_w),
    .rect_h      (rect_h),
    .fill_colour (fill_colour),
    .mem_rd_data (mem_rd_data),
    .busy        (busy),
    .done        (done),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .rect_x_q    (op_x),
    .rect_y_q    (op_y),
    .rect_w_q    (op_w),
    .rect_h_q    (op_h)
  );

  dirty_ring #(.COORD_W(COORD_W), .QDEPTH(QDEPTH)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (done),
    .push_x     (op_x),
    .push_y     (op_y),
    .push_w     (op_w),
    .push_h     (op_h),
    .invalidate (dirty_invalidate),
    .pop        (dirty_pop),
    .lim_w      (scr_width),
    .lim_h      (scr_height),
    .valid      (dirty_valid),
    .out_x      (dirty_x),
    .out_y      (dirty_y),
    .out_w      (dirty_w),
    .out_h      (dirty_h)
  );

endmodule

// File: tb/test_rect_blit_engine.sv
module test_rect_blit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 12;
  localparam int MEMSZ = 4096;
  localparam logic [AW-1:0] BASE = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_copy = 1'b0;
  logic [2:0] bpp = 3'd1;
  logic [CW-1:0] scr_width = 12'd16, scr_height = 12'd12;
  logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, rect_w = '0, rect_h = '0;
  logic [31:0] fill_colour = '0;
  logic busy, done, mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data, mem_wr_data;
  logic dirty_invalidate = 1'b0, dirty_pop = 1'b0, dirty_valid;
  logic [CW-1:0] dirty_x, dirty_y, dirty_w, dirty_h;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_blit_engine #(.ADDR_W(AW), .COORD_W(CW), .QDEPTH(512)) i_rect_blit_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_copy(op_copy), .bpp(bpp),
    .scr_width(scr_width), .scr_height(scr_height), .fb_base(BASE),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .rect_w(rect_w), .rect_h(rect_h), .fill_colour(fill_colour),
    .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .dirty_invalidate(dirty_invalidate), .dirty_pop(dirty_pop),
    .dirty_valid(dirty_valid), .dirty_x(dirty_x), .dirty_y(dirty_y),
    .dirty_w(dirty_w), .dirty_h(dirty_h)
  );

  // Framebuffer model
  logic [7:0] mem [MEMSZ];
  logic [7:0] expm [MEMSZ];
  logic prefill = 1'b0;
  int wr_count = 0;
  always @(posedge clk) begin
    if (prefill) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (mem_wr_en) begin
        mem[mem_wr_addr[11:0]] <= mem_wr_data;
        wr_count <= wr_count + 1;
      end
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];
    end
  end

  int checks = 0, errors = 0;
  logic [4*CW-1:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int addr_of(int b, int x, int y, int k);
    return int'(BASE) + b * x + b * int'(scr_width) * y + k;
  endfunction

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < MEMSZ; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, req, "framebuffer mismatches", bad, 0);
    if (first >= 0) chk(1'b0, req, $sformatf("byte @%0d", first), mem[first], expm[first]);
  endtask

  task automatic launch_wait(output int cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_fill(input string req, input int b, input int x, input int y,
                         input int w, input int h, input logic [31:0] c);
    int cyc, w0;
    for (int r = 0; r < h; r++)
      for (int k = 0; k < b * w; k++)
        expm[addr_of(b, x, y + r, k)] = c[8*(k % b) +: 8];
    exp_q.push_back({CW'(x), CW'(y), CW'(w), CW'(h)});
    op_copy = 1'b0; bpp = 3'(b); dst_x = CW'(x); dst_y = CW'(y);
    rect_w = CW'(w); rect_h = CW'(h); fill_colour = c;
    w0 = wr_count;
    launch_wait(cyc);
    chk(cyc == b * w * h + 1, req, "fill cycles to done", cyc, b * w * h + 1);
    chk(wr_count - w0 == b * w * h, req, "fill write count", wr_count - w0, b * w * h);
    cmp_mem(req);
  endtask

  task automatic do_copy(input string req, input int b, input int sx, input int sy,
                         input int dx, input int dy, input int w, input int h);
    int cyc, w0;
    logic [7:0] tmp [$];
    for (int r = 0; r < h; r++)
      for (int k = 0; k < b * w; k++) tmp.push_back(expm[addr_of(b, sx, sy + r, k)]);
    for (int r = 0; r < h; r++)
      for (int k = 0; k < b * w; k++) expm[addr_of(b, dx, dy + r, k)] = tmp.pop_front();
    exp_q.push_back({CW'(dx), CW'(dy), CW'(w), CW'(h)});
    op_copy = 1'b1; bpp = 3'(b); src_x = CW'(sx); src_y = CW'(sy);
    dst_x = CW'(dx); dst_y = CW'(dy); rect_w = CW'(w); rect_h = CW'(h);
    w0 = wr_count;
    launch_wait(cyc);
    chk(cyc == 2 * b * w * h + 1, req, "copy cycles to done", cyc, 2 * b * w * h + 1);
    chk(wr_count - w0 == b * w * h, req, "copy write count", wr_count - w0, b * w * h);
    cmp_mem(req);
  endtask

  function automatic void clip1(input int p, input int l, input int lim,
                                output int op, output int ol);
    if (p + l > lim) begin
      op = (p > lim) ? lim : p;
      ol = lim - op;
    end else begin
      op = p; ol = l;
    end
  endfunction

  // Monitor side of the scoreboard: pop design entries and compare
  task automatic drain(input string req);
    int ex, ey, ew, eh;
    logic [4*CW-1:0] e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      clip1(int'(e[4*CW-1 -: CW]), int'(e[2*CW-1 -: CW]), int'(scr_width), ex, ew);
      clip1(int'(e[3*CW-1 -: CW]), int'(e[CW-1:0]), int'(scr_height), ey, eh);
      @(negedge clk);
      chk(dirty_valid === 1'b1, req, "dirty_valid", dirty_valid, 1);
      chk(dirty_x == CW'(ex) && dirty_w == CW'(ew), req, "dirty x,w",
          {dirty_x, dirty_w}, {CW'(ex), CW'(ew)});
      chk(dirty_y == CW'(ey) && dirty_h == CW'(eh), req, "dirty y,h",
          {dirty_y, dirty_h}, {CW'(ey), CW'(eh)});
      dirty_pop = 1'b1;
      @(negedge clk);
      dirty_pop = 1'b0;
    end
    @(negedge clk);
    chk(dirty_valid === 1'b0, req, "queue empty after drain", dirty_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, w0;
    for (int i = 0; i < MEMSZ; i++) expm[i] = 8'(i * 7 + 3);
    prefill = 1'b1;
    repeat (2) @(negedge clk);
    prefill = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk(!busy && !done && !dirty_valid, "R5", "idle after reset",
        {busy, done, dirty_valid}, 0);
    cmp_mem("R5");

    // R1 R2 fills at each pixel size
    do_fill("R1", 4, 2, 3, 3, 2, 32'hA1B2C3D4);
    do_fill("R2", 3, 5, 6, 4, 3, 32'h00112233);
    do_fill("R2", 1, 0, 0, 7, 1, 32'h0000005A);
    do_fill("R2", 2, 9, 10, 5, 2, 32'h0000BEEF);
    drain("R6");

    // R3 disjoint and downward-overlap copies
    do_copy("R3", 2, 0, 0, 8, 8, 3, 2);
    do_copy("R3", 1, 1, 1, 2, 3, 4, 4);
    // R4 upward shift, same-row right and left shifts
    do_copy("R4", 2, 3, 5, 5, 4, 5, 3);
    do_copy("R4", 3, 1, 2, 3, 2, 6, 2);
    do_copy("R4", 1, 4, 7, 2, 7, 6, 1);
    drain("R6");

    // R10 zero-sized operations
    do_fill("R10", 2, 3, 3, 0, 4, 32'hFFFFFFFF);
    do_copy("R10", 1, 0, 0, 5, 5, 3, 0);
    drain("R10");

    // R11 operands and second start ignored while busy
    for (int k = 0; k < 4; k++) expm[addr_of(2, 0, 11, k)] = (k % 2 == 0) ? 8'h77 : 8'h66;
    exp_q.push_back({CW'(0), CW'(11), CW'(2), CW'(1)});
    op_copy = 1'b0; bpp = 3'd2; dst_x = '0; dst_y = 12'd11; rect_w = 12'd2; rect_h = 12'd1;
    fill_colour = 32'h00006677;
    w0 = wr_count;
    @(negedge clk); start = 1'b1;
    @(negedge clk); bpp = 3'd4; dst_x = 12'd5; fill_colour = 32'h12345678;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    chk(!busy, "R11", "idle after single op", busy, 0);
    chk(wr_count - w0 == 4, "R11", "writes with mid-op changes", wr_count - w0, 4);
    cmp_mem("R11");
    drain("R11");

    // R7 R8 clipping against a shrunken screen
    do_fill("R7", 1, 10, 8, 4, 3, 32'h000000C1);
    do_fill("R8", 1, 13, 10, 2, 2, 32'h000000C2);
    do_fill("R7", 1, 1, 1, 2, 2, 32'h000000C3);
    scr_width = 12'd12; scr_height = 12'd9;
    drain("R7");
    scr_width = 12'd16; scr_height = 12'd12;

    // R9 invalidate drops pending entries
    do_fill("R9", 1, 0, 0, 1, 1, 32'h1);
    do_fill("R9", 1, 1, 0, 1, 1, 32'h2);
    exp_q.delete();
    @(negedge clk); dirty_invalidate = 1'b1;
    @(negedge clk); dirty_invalidate = 1'b0;
    chk(dirty_valid === 1'b0, "R9", "valid after invalidate", dirty_valid, 0);
    dirty_pop = 1'b1;
    @(negedge clk); dirty_pop = 1'b0;
    @(negedge clk);
    chk(dirty_valid === 1'b0, "R6", "pop on empty has no effect", dirty_valid, 0);
    do_fill("R6", 1, 2, 2, 1, 1, 32'h3);
    drain("R6");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule